// File: doc/BRIEF.md
# Chainable Two-Lane SIMD Functional Slice

This block holds the arithmetic units of two neighbouring 16-bit SIMD lanes and a small crossbar between them. Each lane can add, subtract, multiply, do bitwise logic or pass an operand through. In parallel mode the lanes work side by side: both run their own opcode on their own operand pair, and both results come out one cycle later with a writeback enable for each lane.

In chained mode the pair becomes a two-stage pipeline. Lane 0 runs the first instruction. The result goes straight through the crossbar into lane 1, which runs the second instruction on it one cycle later. The intermediate value never leaves the slice, so only lane 1 requests a writeback. A new chained operation can be issued on every cycle. Four such slices make up one 8-wide SIMD group.

Top module: `lps_chain_slice`

## Requirements
- R1: While reset is asserted, and after it is released until the first issue, `o_valid` is 0, `o_we` is 00, and `o_r0` and `o_r1` are 0.
- R2: Opcode encodings, with all arithmetic modulo 2^16: 0 gives A+B, 1 gives A-B, 2 gives the low 16 bits of A*B, 3 gives A AND B, 4 gives A OR B, 5 gives A XOR B, 6 passes A through, and 7 gives 0.
- R3: A parallel issue (`i_valid`=1, `i_chain`=0) puts op0(a0,b0) on `o_r0` and op1(a1,b1) on `o_r1` one clock edge after capture. It also drives `o_valid`=1 and `o_we`=11 (bit 0 is lane 0, bit 1 is lane 1).
- R4: A chained issue (`i_chain`=1) puts its result on `o_r1` two clock edges after capture, with `o_valid`=1, `o_we`=10 and `o_r0`=0. Lane 1 applies op1 to the lane 0 result op0(a0,b0).
- R5: Crossbar select: with `i_xsel`=0, the lane 0 result is operand A of the second stage and `i_b1` is operand B. With `i_xsel`=1, `i_a1` is operand A and the lane 0 result is operand B.
- R6: Chained issues on consecutive cycles each produce one result, on consecutive cycles and in issue order.
- R7: A parallel issue in the cycle right after a chained issue is discarded, because lane 1 is busy with the second stage. It produces no output, and the chained result appears unchanged.
- R8: A cycle with no result drives `o_valid`=0 and `o_we`=00, and `o_r0` and `o_r1` keep their previous values.
- R9: A chained issue in the cycle right after a parallel issue is accepted. Both results appear, the parallel result first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| i_valid | input | 1 | Issue strobe |
| i_chain | input | 1 | 1 = chained mode, 0 = parallel mode |
| i_xsel | input | 1 | Crossbar select: which second-stage operand receives the lane 0 result |
| i_op0 | input | 3 | Lane 0 opcode (first stage in chained mode) |
| i_op1 | input | 3 | Lane 1 opcode (second stage in chained mode) |
| i_a0 | input | 16 | Lane 0 operand A |
| i_b0 | input | 16 | Lane 0 operand B |
| i_a1 | input | 16 | Lane 1 operand A |
| i_b1 | input | 16 | Lane 1 operand B |
| o_valid | output | 1 | Result valid |
| o_we | output | 2 | Per-lane writeback enable |
| o_r0 | output | 16 | Lane 0 result |
| o_r1 | output | 16 | Lane 1 result |

## Verification
If the stage register between the lanes holds a wrong valid bit or a stale opcode, the fault shows on the very next edge. It appears as a missing or extra result, as a `o_we` pattern that does not match the mode, or as a wrong `o_r1`. A lost drop rule would let a parallel result appear in the same cycle as a chained one, or one cycle late. That shows up as a result nobody issued, or one out of order, within two cycles of the issue. Results that change while `o_valid` is low point to a bad hold path, and that is visible on the first idle cycle.

// File: rtl/lps_pkg.sv
package lps_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_MUL  = 3'd2,
        OP_AND  = 3'd3,
        OP_OR   = 3'd4,
        OP_XOR  = 3'd5,
        OP_PASS = 3'd6,
        OP_NONE = 3'd7
    } lps_op_e;

    localparam int unsigned LANES = 2;

endpackage

// File: rtl/lps_lane.sv
module lps_lane
    import lps_pkg::*;
#(
    parameter int unsigned DW = 16
) (
    input  logic [2:0]    op,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    output logic [DW-1:0] res
);
    localparam int unsigned PW = 2 * DW;

    logic [PW-1:0] prod;
    logic [DW-1:0] sum;
    logic [DW-1:0] logic_y;
    logic [DW-1:0] perm_y;
    lps_op_e       op_e;

    assign op_e = lps_op_e'(op);

    // multiplier: full product, low half kept
    assign prod = PW'(opa) * PW'(opb);

    // adder: subtract by two's complement of B
    always_comb begin
        if (op_e == OP_SUB) sum = opa + (~opb) + DW'(1);
        else                sum = opa + opb;
    end

    // bitwise unit
    always_comb begin
        unique case (op_e)
            OP_AND:  logic_y = opa & opb;
            OP_OR:   logic_y = opa | opb;
            default: logic_y = opa ^ opb;
        endcase
    end

    // permute unit: straight pass of operand A
    assign perm_y = opa;

    always_comb begin
        unique case (op_e)
            OP_ADD, OP_SUB:        res = sum;
            OP_MUL:                res = prod[DW-1:0];
            OP_AND, OP_OR, OP_XOR: res = logic_y;
            OP_PASS:               res = perm_y;
            default:               res = '0;
        endcase
    end

    always_comb begin
        if (op_e == OP_PASS) begin
            AST_PASS_IS_A: assert (res == opa); // R2
        end
    end

endmodule

// File: rtl/lps_xbar.sv
module lps_xbar #(
    parameter int unsigned DW = 16
) (
    input  logic          sel,
    input  logic [DW-1:0] inter,
    input  logic [DW-1:0] other,
    output logic [DW-1:0] opa,
    output logic [DW-1:0] opb
);
    always_comb begin
        if (sel) begin
            opa = other;
            opb = inter;
        end else begin
            opa = inter;
            opb = other;
        end
    end

    always_comb begin
        AST_XBAR_ROUTES_INTER: assert (opa == inter || opb == inter); // R5
    end

endmodule

// File: rtl/lps_chain_slice.sv
module lps_chain_slice
    import lps_pkg::*;
#(
    parameter int unsigned DW  = 16,
    parameter int unsigned OPW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           i_valid,
    input  logic           i_chain,
    input  logic           i_xsel,
    input  logic [OPW-1:0] i_op0,
    input  logic [OPW-1:0] i_op1,
    input  logic [DW-1:0]  i_a0,
    input  logic [DW-1:0]  i_b0,
    input  logic [DW-1:0]  i_a1,
    input  logic [DW-1:0]  i_b1,
    output logic           o_valid,
    output logic [1:0]     o_we,
    output logic [DW-1:0]  o_r0,
    output logic [DW-1:0]  o_r1
);
    localparam logic [LANES-1:0] WE_ALL   = '1;
    localparam logic [LANES-1:0] WE_CHAIN = LANES'(1) << (LANES - 1);

    typedef struct packed {
        logic           vld;
        logic           sel;
        logic [OPW-1:0] op;
        logic [DW-1:0]  inter;
        logic [DW-1:0]  other;
    } stage_t;

    typedef struct packed {
        logic             vld;
        logic [LANES-1:0] we;
        logic [DW-1:0]    r0;
        logic [DW-1:0]    r1;
    } out_t;

    typedef struct packed {
        stage_t st;
        out_t   out;
    } state_t;

    state_t state_d, state_q;

    logic [OPW-1:0] lane_op  [LANES];
    logic [DW-1:0]  lane_a   [LANES];
    logic [DW-1:0]  lane_b   [LANES];
    logic [DW-1:0]  lane_y   [LANES];
    logic [DW-1:0]  xb_a, xb_b;
    logic           par_ok;

    lps_xbar #(.DW(DW)) u_xbar (
        .sel   (state_q.st.sel),
        .inter (state_q.st.inter),
        .other (state_q.st.other),
        .opa   (xb_a),
        .opb   (xb_b)
    );

    // operand steering: lane 1 serves the second stage while it is occupied
    always_comb begin
        lane_op[0] = i_op0;
        lane_a[0]  = i_a0;
        lane_b[0]  = i_b0;
        if (state_q.st.vld) begin
            lane_op[1] = state_q.st.op;
            lane_a[1]  = xb_a;
            lane_b[1]  = xb_b;
        end else begin
            lane_op[1] = i_op1;
            lane_a[1]  = i_a1;
            lane_b[1]  = i_b1;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lps_lane #(.DW(DW)) u_lane (
            .op  (lane_op[g]),
            .opa (lane_a[g]),
            .opb (lane_b[g]),
            .res (lane_y[g])
        );
    end

    assign par_ok = i_valid && !i_chain && !state_q.st.vld;

    always_comb begin
        state_d = state_q;

        state_d.st.vld   = i_valid && i_chain;
        state_d.st.sel   = i_xsel;
        state_d.st.op    = i_op1;
        state_d.st.inter = lane_y[0];
        state_d.st.other = i_xsel ? i_a1 : i_b1;

        if (state_q.st.vld) begin
            state_d.out.vld = 1'b1;
            state_d.out.we  = WE_CHAIN;
            state_d.out.r0  = '0;
            state_d.out.r1  = lane_y[1];
        end else if (par_ok) begin
            state_d.out.vld = 1'b1;
            state_d.out.we  = WE_ALL;
            state_d.out.r0  = lane_y[0];
            state_d.out.r1  = lane_y[1];
        end else begin
            state_d.out.vld = 1'b0;
            state_d.out.we  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign o_valid = state_q.out.vld;
    assign o_we    = state_q.out.we;
    assign o_r0    = state_q.out.r0;
    assign o_r1    = state_q.out.r1;

    AST_PAR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (i_valid && !i_chain && !state_q.st.vld) |=> (o_valid && o_we == 2'b11)); // R3
    AST_CHAIN_ENTERS_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (i_valid && i_chain) |=> state_q.st.vld); // R4
    AST_CHAIN_SECOND_STAGE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.st.vld |=> (o_valid && o_we == 2'b10 && o_r0 == '0)); // R4
    AST_DROP_AFTER_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.st.vld && i_valid && !i_chain) |=> (o_we == 2'b10)); // R7
    AST_IDLE_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
        !o_valid |-> (o_we == 2'b00)); // R8
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!o_valid && $past(rst_n)) |-> ($stable(o_r0) && $stable(o_r1))); // R8

endmodule

// File: tb/sim_lps_chain_slice.sv
`timescale 1ns/1ps
module sim_lps_chain_slice;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        i_valid = 1'b0, i_chain = 1'b0, i_xsel = 1'b0;
    logic [2:0]  i_op0 = '0, i_op1 = '0;
    logic [15:0] i_a0 = '0, i_b0 = '0, i_a1 = '0, i_b1 = '0;
    logic        o_valid;
    logic [1:0]  o_we;
    logic [15:0] o_r0, o_r1;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit running = 1'b0;
    bit prev_ch = 1'b0;
    logic [15:0] last_r0 = '0, last_r1 = '0;

    typedef struct {
        int          due;
        logic [15:0] r0;
        logic [15:0] r1;
        logic [1:0]  we;
        string       tag;
    } exp_t;
    exp_t q[$];

    always #2.5 clk = ~clk;

    lps_chain_slice u0 (
        .clk(clk), .rst_n(rst_n), .i_valid(i_valid), .i_chain(i_chain),
        .i_xsel(i_xsel), .i_op0(i_op0), .i_op1(i_op1),
        .i_a0(i_a0), .i_b0(i_b0), .i_a1(i_a1), .i_b1(i_b1),
        .o_valid(o_valid), .o_we(o_we), .o_r0(o_r0), .o_r1(o_r1)
    );

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    function automatic logic [15:0] ref_op(logic [2:0] op, logic [15:0] a, logic [15:0] b);
        logic [31:0] p;
        p = {16'd0, a} * {16'd0, b};
        case (op)
            3'd0: return a + b;
            3'd1: return a - b;
            3'd2: return p[15:0];
            3'd3: return a & b;
            3'd4: return a | b;
            3'd5: return a ^ b;
            3'd6: return a;
            default: return 16'd0;
        endcase
    endfunction

    task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic issue(bit v, bit ch, bit xs, logic [2:0] op0, logic [2:0] op1,
                         logic [15:0] a0, logic [15:0] b0, logic [15:0] a1, logic [15:0] b1,
                         string tag);
        exp_t e;
        logic [15:0] inter;
        @(posedge clk); #1;
        i_valid = v; i_chain = ch; i_xsel = xs; i_op0 = op0; i_op1 = op1;
        i_a0 = a0; i_b0 = b0; i_a1 = a1; i_b1 = b1;
        if (v) begin
            if (ch) begin
                inter = ref_op(op0, a0, b0);
                e.due = cyc + 2;
                e.r0  = 16'd0;
                e.r1  = xs ? ref_op(op1, a1, inter) : ref_op(op1, inter, b1);
                e.we  = 2'b10;
                e.tag = tag;
                q.push_back(e);
            end else if (!prev_ch) begin
                e.due = cyc + 1;
                e.r0  = ref_op(op0, a0, b0);
                e.r1  = ref_op(op1, a1, b1);
                e.we  = 2'b11;
                e.tag = tag;
                q.push_back(e);
            end
        end
        prev_ch = v && ch;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) issue(1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 16'd0, 16'd0, 16'd0, 16'd0, "R8");
    endtask

    // monitor: pops expected results as the design produces them
    always @(negedge clk) begin
        if (running) begin
            if (o_valid) begin
                if (q.size() == 0) begin
                    check(1'b0, "R7", "unexpected result r1", {16'd0, o_r1}, 32'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(e.due == cyc, e.tag, "result cycle", cyc, e.due);
                    check(o_r0 == e.r0, e.tag, "o_r0", {16'd0, o_r0}, {16'd0, e.r0});
                    check(o_r1 == e.r1, e.tag, "o_r1", {16'd0, o_r1}, {16'd0, e.r1});
                    check(o_we == e.we, e.tag, "o_we", {30'd0, o_we}, {30'd0, e.we});
                end
            end else begin
                check(o_we == 2'b00, "R8", "o_we idle", {30'd0, o_we}, 32'd0);
                check(o_r0 == last_r0 && o_r1 == last_r1, "R8", "results held",
                      {o_r0, o_r1}, {last_r0, last_r1});
                if (q.size() != 0 && q[0].due <= cyc) begin
                    check(1'b0, q[0].tag, "missing result", 32'd0, q[0].due);
                    void'(q.pop_front());
                end
            end
            last_r0 = o_r0;
            last_r1 = o_r1;
        end
    end

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(o_valid == 1'b0 && o_we == 2'b00 && o_r0 == 16'd0 && o_r1 == 16'd0,
              "R1", "outputs in reset", {o_valid, o_we, o_r0[12:0], o_r1}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(o_valid == 1'b0 && o_we == 2'b00 && o_r0 == 16'd0 && o_r1 == 16'd0,
              "R1", "outputs after reset", {o_valid, o_we, o_r0[12:0], o_r1}, 32'd0);
        running = 1'b1;

        // R2 / R3: every opcode in parallel mode, including wrap cases
        issue(1, 0, 0, 3'd0, 3'd1, 16'hFFFF, 16'h0002, 16'h0000, 16'h0001, "R2_add_sub_wrap");
        issue(1, 0, 0, 3'd2, 3'd2, 16'h1234, 16'h0100, 16'hFFFF, 16'hFFFF, "R2_mul_low");
        issue(1, 0, 0, 3'd3, 3'd4, 16'hF0F0, 16'h3C3C, 16'hF0F0, 16'h0F0F, "R2_and_or");
        issue(1, 0, 0, 3'd5, 3'd6, 16'hAAAA, 16'hFFFF, 16'hBEEF, 16'h1111, "R2_xor_pass");
        issue(1, 0, 0, 3'd7, 3'd0, 16'h1234, 16'h5678, 16'h7FFF, 16'h0001, "R2_none_R3");
        idle(2);

        // R4 / R5: chained, both crossbar selections, non-commutative op
        issue(1, 1, 0, 3'd0, 3'd1, 16'h0010, 16'h0005, 16'h9999, 16'h0003, "R5_sel0");
        idle(3);
        issue(1, 1, 1, 3'd0, 3'd1, 16'h0010, 16'h0005, 16'h0100, 16'h9999, "R5_sel1");
        idle(3);
        issue(1, 1, 0, 3'd2, 3'd0, 16'h0300, 16'h0101, 16'h0000, 16'hFFFF, "R4_mul_add");

        // R6: back-to-back chained stream
        for (int k = 0; k < 6; k++)
            issue(1, 1, k[0], 3'(k % 7), 3'((k + 3) % 7), 16'(16'h1111 * (k + 1)),
                  16'(16'h0F0F + k), 16'(16'h2222 + k), 16'(16'h0303 * (k + 2)), "R6_stream");
        idle(3);

        // R7: parallel right after chained is discarded
        issue(1, 1, 0, 3'd0, 3'd5, 16'h0001, 16'h0002, 16'h0000, 16'h00FF, "R7_chain");
        issue(1, 0, 0, 3'd0, 3'd0, 16'h4444, 16'h4444, 16'h5555, 16'h5555, "R7_dropped");
        idle(4);

        // R9: chained right after parallel
        issue(1, 0, 0, 3'd1, 3'd3, 16'h0005, 16'h0007, 16'hFF00, 16'h0FF0, "R9_par");
        issue(1, 1, 1, 3'd4, 3'd1, 16'h0F00, 16'h00F0, 16'h1000, 16'h0000, "R9_chain");
        issue(1, 0, 0, 3'd0, 3'd0, 16'h0001, 16'h0001, 16'h0002, 16'h0002, "R7_after_R9");
        issue(1, 0, 0, 3'd2, 3'd5, 16'h0007, 16'h0009, 16'h00FF, 16'h0F0F, "R3_resume");
        idle(5);

        check(q.size() == 0, "R6", "queue drained", q.size(), 32'd0);
        running = 1'b0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule